// File: doc/BRIEF.md
# Subcarrier Equaliser and Walsh Despreader

This block sits in a multicarrier spread-spectrum receiver after the FFT and frequency deinterleaving. Every cycle it can accept one frequency-domain subcarrier sample with the channel estimate for that subcarrier. It weights the sample with a single-user combining rule, which is chosen at run time from four rules: maximum ratio, equal gain, orthogonality restoring and minimum mean square error. It then despreads the weighted chips with the Walsh-Hadamard code of one chosen user. Each group of NU chips produces one soft QPSK symbol, the I/Q pair that a demapper needs.

The channel estimate comes from the pilot symbol at the head of each frame and stays unchanged for the data symbols of that frame, so the caller marks the first sample of each frame. The combining rule and the user index are captured only on that marked sample. All divisions needed by the weights are built from shift-and-subtract logic, so no divider macro is involved.

Top module: `mc_eq_despread`

## Requirements
- R1: While rst_ni is low, and after it rises until the first symbol completes, sym_valid_o is 0 and sym_re_o and sym_im_o are 0.
- R2: Mode 0 (maximum ratio) gives the chip value P >>> 11 (floor shift). P = x·conj(h) is the full-precision complex product, with real part xr·hr + xi·hi and imaginary part xi·hr − xr·hi.
- R3: Mode 1 (equal gain) gives the chip value P / m, truncated toward zero. Here m = max(|hr|,|hi|) + floor(min(|hr|,|hi|)/2).
- R4: Mode 2 (orthogonality restoring) gives the chip value (P·1024) / (hr² + hi²), truncated toward zero.
- R5: Mode 3 (MMSE) gives the chip value (P·1024) / (hr² + hi² + 66365), truncated toward zero. The constant 66365 is the noise term for a 12 dB SNR at a channel amplitude of 1024.
- R6: Each chip value is saturated to the signed 16-bit range [−32768, 32767] before despreading.
- R7: In modes 1 and 2, a zero divisor gives a chip value of 0.
- R8: Chip k of a group (k = 0..NU−1) for user u counts negative when the number of ones in (u AND k) is odd, and positive otherwise. The symbol is floor(sum of signed chips / NU), taken separately for I and Q.
- R9: mode_i and user_i are taken only when valid_i and sof_i are both high, and they apply from that sample onward; at any other time they have no effect. A sample with sof_i high is chip 0 of a new group, and any partial group in progress is discarded.
- R10: When chip NU−1 is accepted on clock edge n, sym_valid_o is high for exactly the cycle after edge n+1, and it is low at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Sample present this cycle |
| sof_i | input | 1 | First sample of a frame |
| x_re_i | input | W (12) | Received sample, real, signed |
| x_im_i | input | W (12) | Received sample, imaginary, signed |
| h_re_i | input | W (12) | Channel estimate, real, signed |
| h_im_i | input | W (12) | Channel estimate, imaginary, signed |
| mode_i | input | 2 | Combining rule: 0 max ratio, 1 equal gain, 2 orthogonality restoring, 3 MMSE |
| user_i | input | log2(NU) | Index of the user to despread |
| sym_valid_o | output | 1 | Soft symbol present |
| sym_re_o | output | OW (16) | Soft symbol, I, signed |
| sym_im_o | output | OW (16) | Soft symbol, Q, signed |

## Verification
The bench runs each combining rule on random full-range samples and channels. The signs and the odd and even magnitudes then separate truncation toward zero from floor rounding, and they separate the four divisor forms. A sweep across all user indices exposes any wrong Walsh row or a wrong chip order. A zero channel, and a tiny channel paired with large samples, test the zero-divisor and saturation paths. Changing mode and user in the middle of a frame, and starting a new frame after a partial group, show that the settings are captured only at the frame start and that the group count restarts there.

// File: rtl/eqd_pkg.sv
package eqd_pkg;
  typedef enum logic [1:0] {
    CMB_MRC  = 2'd0,
    CMB_EGC  = 2'd1,
    CMB_ORC  = 2'd2,
    CMB_MMSE = 2'd3
  } cmb_mode_e;
endpackage

// File: rtl/eqd_div.sv
// Unrolled restoring divider: unsigned num / den, one subtract stage per quotient bit.
module eqd_div #(
  parameter int NW = 35,
  parameter int DW = 25
) (
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic [NW-1:0] quo_o
);
  localparam int PW = NW + DW;

  logic [DW-1:0] rem [NW+1];
  assign rem[0] = '0;

  for (genvar i = 0; i < NW; i++) begin : g_stage
    logic [DW:0] trial;
    logic        ge;
    assign trial = {rem[i], num_i[NW-1-i]};
    assign ge    = trial >= {1'b0, den_i};
    assign rem[i+1] = ge ? DW'(trial - {1'b0, den_i}) : DW'(trial);
    assign quo_o[NW-1-i] = ge;
  end

  always_comb begin
    if (den_i != '0) begin
      p_div_exact_r4: assert ((PW'(quo_o) * PW'(den_i) <= PW'(num_i)) &&
                              (PW'(num_i) - PW'(quo_o) * PW'(den_i) < PW'(den_i)))
        else $error("divider quotient out of bounds");
    end
  end
endmodule

// File: rtl/eqd_weight.sv
// Combinational per-subcarrier combining: x*conj(h) scaled per selected rule, saturated.
module eqd_weight
  import eqd_pkg::*;
#(
  parameter int W      = 12,
  parameter int OW     = 16,
  parameter int FRAC   = 10,
  parameter int MRC_SH = 11,
  parameter int SIGMA2 = 66365
) (
  input  logic signed [W-1:0]  x_re_i,
  input  logic signed [W-1:0]  x_im_i,
  input  logic signed [W-1:0]  h_re_i,
  input  logic signed [W-1:0]  h_im_i,
  input  cmb_mode_e            mode_i,
  output logic signed [OW-1:0] y_re_o,
  output logic signed [OW-1:0] y_im_o
);
  localparam int PW = 2*W + 1;
  localparam int NW = PW + FRAC;
  localparam int DW = 2*W + 1;
  localparam int WW = NW + 2;
  localparam logic signed [WW-1:0] SMAX = (WW'(1) <<< (OW-1)) - WW'(1);
  localparam logic signed [WW-1:0] SMIN = -SMAX - WW'(1);

  logic signed [2*W-1:0] m_rr, m_ii, m_ir, m_ri;
  logic signed [PW-1:0]  prod [2];
  assign m_rr = x_re_i * h_re_i;
  assign m_ii = x_im_i * h_im_i;
  assign m_ir = x_im_i * h_re_i;
  assign m_ri = x_re_i * h_im_i;
  assign prod[0] = PW'(m_rr) + PW'(m_ii);
  assign prod[1] = PW'(m_ir) - PW'(m_ri);

  // channel magnitude terms
  logic [W-1:0]   ha_re, ha_im, h_max, h_min;
  logic [W:0]     mag;
  logic [2*W-1:0] sq_re, sq_im;
  logic [2*W:0]   pw;
  assign ha_re = h_re_i[W-1] ? W'(-h_re_i) : W'(h_re_i);
  assign ha_im = h_im_i[W-1] ? W'(-h_im_i) : W'(h_im_i);
  assign h_max = (ha_re >= ha_im) ? ha_re : ha_im;
  assign h_min = (ha_re >= ha_im) ? ha_im : ha_re;
  assign mag   = (W+1)'(h_max) + (W+1)'(h_min >> 1);
  assign sq_re = ha_re * ha_re;
  assign sq_im = ha_im * ha_im;
  assign pw    = (2*W+1)'(sq_re) + (2*W+1)'(sq_im);

  logic [DW-1:0] den;
  always_comb begin
    unique case (mode_i)
      CMB_EGC:  den = DW'(mag);
      CMB_ORC:  den = DW'(pw);
      CMB_MMSE: den = DW'(pw) + DW'(SIGMA2);
      default:  den = DW'(1);
    endcase
  end

  logic signed [OW-1:0] y [2];

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic [PW-1:0]        amag;
    logic [NW-1:0]        num, quo;
    logic signed [WW-1:0] qs, wide;
    assign amag = prod[k][PW-1] ? PW'(-prod[k]) : PW'(prod[k]);
    assign num  = (mode_i == CMB_EGC) ? NW'(amag) : (NW'(amag) << FRAC);

    eqd_div #(.NW(NW), .DW(DW)) u_div (
      .num_i (num),
      .den_i (den),
      .quo_o (quo)
    );

    assign qs = prod[k][PW-1] ? -$signed({2'b00, quo}) : $signed({2'b00, quo});

    always_comb begin
      if (mode_i == CMB_MRC)  wide = WW'(prod[k] >>> MRC_SH);
      else if (den == '0)     wide = '0;
      else                    wide = qs;
      if (wide > SMAX)        y[k] = OW'(SMAX);
      else if (wide < SMIN)   y[k] = OW'(SMIN);
      else                    y[k] = OW'(wide);
    end
  end

  assign y_re_o = y[0];
  assign y_im_o = y[1];
endmodule

// File: rtl/eqd_despread.sv
// Walsh-Hadamard despreader: signed chip accumulation over NU chips, divide by shift.
module eqd_despread #(
  parameter int NU = 8,
  parameter int OW = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      eq_valid_i,
  input  logic                      eq_sof_i,
  input  logic [$clog2(NU)-1:0]     user_i,
  input  logic signed [OW-1:0]      eq_re_i,
  input  logic signed [OW-1:0]      eq_im_i,
  output logic                      sym_valid_o,
  output logic signed [OW-1:0]      sym_re_o,
  output logic signed [OW-1:0]      sym_im_o
);
  localparam int L  = $clog2(NU);
  localparam int AW = OW + L + 1;

  logic [L-1:0] cnt_q, idx;
  logic         neg, last;
  assign idx  = eq_sof_i ? '0 : cnt_q;
  assign neg  = ^(user_i & idx);
  assign last = (idx == L'(NU-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      sym_valid_o <= 1'b0;
    end else begin
      sym_valid_o <= eq_valid_i && last;
      if (eq_valid_i) cnt_q <= last ? '0 : idx + L'(1);
    end
  end

  logic signed [OW-1:0] chip [2];
  logic signed [OW-1:0] sym  [2];
  assign chip[0] = eq_re_i;
  assign chip[1] = eq_im_i;

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic signed [AW-1:0] acc_q, term, sum;
    logic signed [OW-1:0] sym_q;
    assign term = neg ? -AW'(chip[k]) : AW'(chip[k]);
    assign sum  = (eq_sof_i ? '0 : acc_q) + term;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q <= '0;
        sym_q <= '0;
      end else if (eq_valid_i) begin
        if (last) begin
          acc_q <= '0;
          sym_q <= OW'(sum >>> L);
        end else begin
          acc_q <= sum;
        end
      end
    end
    assign sym[k] = sym_q;
  end

  assign sym_re_o = sym[0];
  assign sym_im_o = sym[1];
endmodule

// File: rtl/mc_eq_despread.sv
module mc_eq_despread
  import eqd_pkg::*;
#(
  parameter int W      = 12,
  parameter int OW     = 16,
  parameter int NU     = 8,
  parameter int FRAC   = 10,
  parameter int MRC_SH = 11,
  localparam int UW    = $clog2(NU),
  localparam int SIGMA2 = ((2**(2*(W-2))) * 10) / 158
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 sof_i,
  input  logic signed [W-1:0]  x_re_i,
  input  logic signed [W-1:0]  x_im_i,
  input  logic signed [W-1:0]  h_re_i,
  input  logic signed [W-1:0]  h_im_i,
  input  logic [1:0]           mode_i,
  input  logic [UW-1:0]        user_i,
  output logic                 sym_valid_o,
  output logic signed [OW-1:0] sym_re_o,
  output logic signed [OW-1:0] sym_im_o
);
  // frame-boundary capture of run-time settings
  cmb_mode_e     mode_q, eff_mode;
  logic [UW-1:0] user_q, eff_user;
  logic          take;
  assign take     = valid_i && sof_i;
  assign eff_mode = take ? cmb_mode_e'(mode_i) : mode_q;
  assign eff_user = take ? user_i : user_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= CMB_MRC;
      user_q <= '0;
    end else if (take) begin
      mode_q <= eff_mode;
      user_q <= eff_user;
    end
  end

  logic signed [OW-1:0] w_re, w_im;
  eqd_weight #(
    .W(W), .OW(OW), .FRAC(FRAC), .MRC_SH(MRC_SH), .SIGMA2(SIGMA2)
  ) u_weight (
    .x_re_i (x_re_i),
    .x_im_i (x_im_i),
    .h_re_i (h_re_i),
    .h_im_i (h_im_i),
    .mode_i (eff_mode),
    .y_re_o (w_re),
    .y_im_o (w_im)
  );

  // equalised chip register
  logic                 eq_valid, eq_sof;
  logic [UW-1:0]        eq_user;
  logic signed [OW-1:0] eq_re, eq_im;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_valid <= 1'b0;
      eq_sof   <= 1'b0;
      eq_user  <= '0;
      eq_re    <= '0;
      eq_im    <= '0;
    end else begin
      eq_valid <= valid_i;
      if (valid_i) begin
        eq_sof  <= sof_i;
        eq_user <= eff_user;
        eq_re   <= w_re;
        eq_im   <= w_im;
      end
    end
  end

  eqd_despread #(.NU(NU), .OW(OW)) u_despread (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eq_valid_i  (eq_valid),
    .eq_sof_i    (eq_sof),
    .user_i      (eq_user),
    .eq_re_i     (eq_re),
    .eq_im_i     (eq_im),
    .sym_valid_o (sym_valid_o),
    .sym_re_o    (sym_re_o),
    .sym_im_o    (sym_im_o)
  );

  p_settings_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> ($stable(mode_q) && $stable(user_q)))
    else $error("settings changed outside frame start");

  p_user_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> (user_q == $past(user_i)))
    else $error("user index not captured at frame start");

  p_single_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |=> !sym_valid_o)
    else $error("symbol valid held longer than one cycle");

  p_sym_follows_chip_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_o |-> $past(eq_valid))
    else $error("symbol without preceding equalised chip");
endmodule

// File: tb/mc_eq_despread_test.sv
`timescale 1ns/1ps
module mc_eq_despread_test;
  localparam int W  = 12;
  localparam int OW = 16;
  localparam int NU = 8;
  localparam int UW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic                 valid = 1'b0, sof = 1'b0;
  logic signed [W-1:0]  xr = '0, xi = '0, hr = '0, hi = '0;
  logic [1:0]           mode = '0;
  logic [UW-1:0]        user = '0;
  logic                 sym_valid;
  logic signed [OW-1:0] sym_re, sym_im;

  mc_eq_despread #(.W(W), .OW(OW), .NU(NU)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sof_i(sof),
    .x_re_i(xr), .x_im_i(xi), .h_re_i(hr), .h_im_i(hi),
    .mode_i(mode), .user_i(user),
    .sym_valid_o(sym_valid), .sym_re_o(sym_re), .sym_im_o(sym_im)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  function automatic longint sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint tdiv(longint n, longint d);
    if (d == 0) return 0;
    return n / d;
  endfunction

  function automatic longint chip_val(int md, longint p, longint a, longint b);
    longint mx, mn, mg, pw;
    mx = (a > b) ? a : b;
    mn = (a > b) ? b : a;
    mg = mx + mn / 2;
    pw = a * a + b * b;
    case (md)
      0: return sat16(p >>> 11);
      1: return sat16(tdiv(p, mg));
      2: return sat16(tdiv(p * 1024, pw));
      default: return sat16(tdiv(p * 1024, pw + 66365));
    endcase
  endfunction

  // behavioural reference
  int     m_mode = 0, m_user = 0;
  bit     m_eq_v = 0, m_eq_sof = 0;
  int     m_eq_user = 0;
  longint m_eq_re = 0, m_eq_im = 0;
  int     m_cnt = 0;
  longint m_acc_re = 0, m_acc_im = 0;
  bit     m_sym_v = 0;
  longint m_sym_re = 0, m_sym_im = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_user = 0; m_eq_v = 0; m_cnt = 0;
      m_acc_re = 0; m_acc_im = 0; m_sym_v = 0; m_sym_re = 0; m_sym_im = 0;
    end else begin
      m_sym_v = 0;
      if (m_eq_v) begin
        int k;
        longint sre, sim;
        if (m_eq_sof) begin m_cnt = 0; m_acc_re = 0; m_acc_im = 0; end
        k = m_cnt;
        sre = ($countones(m_eq_user & k) % 2 == 1) ? -m_eq_re : m_eq_re;
        sim = ($countones(m_eq_user & k) % 2 == 1) ? -m_eq_im : m_eq_im;
        m_acc_re += sre;
        m_acc_im += sim;
        if (k == NU - 1) begin
          m_sym_v = 1;
          m_sym_re = m_acc_re >>> 3;
          m_sym_im = m_acc_im >>> 3;
          m_acc_re = 0; m_acc_im = 0; m_cnt = 0;
        end else m_cnt = k + 1;
      end
      m_eq_v = valid;
      if (valid) begin
        longint pr, pi, a, b;
        if (sof) begin m_mode = int'(mode); m_user = int'(user); end
        pr = longint'(xr) * longint'(hr) + longint'(xi) * longint'(hi);
        pi = longint'(xi) * longint'(hr) - longint'(xr) * longint'(hi);
        a = (hr < 0) ? -longint'(hr) : longint'(hr);
        b = (hi < 0) ? -longint'(hi) : longint'(hi);
        m_eq_re = chip_val(m_mode, pr, a, b);
        m_eq_im = chip_val(m_mode, pi, a, b);
        m_eq_sof = sof;
        m_eq_user = m_user;
      end
    end
  end

  // comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        checks++;
        if (sym_valid !== 1'b0 || sym_re !== '0 || sym_im !== '0) begin
          errors++;
          $display("FAIL R1 reset outputs: valid=%0b re=%0d im=%0d expected 0 0 0",
                   sym_valid, sym_re, sym_im);
        end
      end else begin
        checks++;
        if (sym_valid !== m_sym_v) begin
          errors++;
          $display("FAIL R10 sym_valid=%0b expected %0b (phase %s)", sym_valid, m_sym_v, cur_req);
        end
        if (m_sym_v) begin
          checks++;
          if (longint'(sym_re) != m_sym_re || longint'(sym_im) != m_sym_im) begin
            errors++;
            $display("FAIL %s symbol re=%0d im=%0d expected re=%0d im=%0d",
                     cur_req, sym_re, sym_im, m_sym_re, m_sym_im);
          end
        end
      end
    end
  end

  task automatic drive(input bit s, input int a, input int b, input int c, input int d,
                       input int md, input int us);
    @(negedge clk);
    valid = 1'b1; sof = s;
    xr = W'(a); xi = W'(b); hr = W'(c); hi = W'(d);
    mode = 2'(md); user = UW'(us);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0; sof = 1'b0;
      xr = W'($urandom); hi = W'($urandom);
    end
  endtask

  function automatic int rnd12();
    return int'($urandom_range(4095)) - 2048;
  endfunction

  // kind 0: random channel, 1: zero channel, 2: tiny channel with large samples
  task automatic frame(input int md, input int us, input int groups, input int kind, input bit gaps);
    for (int c = 0; c < groups * NU; c++) begin
      int a, b, ch, dh;
      a = rnd12(); b = rnd12();
      case (kind)
        1: begin ch = 0; dh = 0; end
        2: begin ch = 1; dh = 0; a = 2047; b = -2048; end
        default: begin ch = rnd12(); dh = rnd12(); end
      endcase
      drive(c == 0, a, b, ch, dh, md, us);
      if (gaps && ($urandom_range(3) == 0)) idle(1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    idle(4);

    cur_req = "R2"; frame(0, 5, 4, 0, 1'b0); frame(0, 2, 3, 0, 1'b1);
    cur_req = "R3"; frame(1, 7, 4, 0, 1'b0); frame(1, 1, 3, 0, 1'b1);
    cur_req = "R4"; frame(2, 3, 4, 0, 1'b0); frame(2, 6, 3, 0, 1'b1);
    cur_req = "R5"; frame(3, 4, 4, 0, 1'b0); frame(3, 0, 3, 0, 1'b1);
    cur_req = "R6"; frame(2, 0, 2, 2, 1'b0); frame(3, 0, 2, 2, 1'b0);
    cur_req = "R7"; frame(1, 3, 2, 1, 1'b0); frame(2, 5, 2, 1, 1'b0);
    cur_req = "R8";
    for (int u = 0; u < NU; u++) frame(0, u, 2, 0, 1'b0);
    for (int u = 0; u < NU; u++) frame(3, u, 1, 0, 1'b1);

    // settings must hold through a frame despite changing inputs
    cur_req = "R9";
    drive(1'b1, rnd12(), rnd12(), rnd12(), rnd12(), 2, 3);
    for (int c = 1; c < 3 * NU; c++)
      drive(1'b0, rnd12(), rnd12(), rnd12(), rnd12(), c % 4, (c * 5) % NU);
    // partial group, then new frame restarts the count
    drive(1'b1, rnd12(), rnd12(), rnd12(), rnd12(), 1, 6);
    for (int c = 1; c < 3; c++) drive(1'b0, rnd12(), rnd12(), rnd12(), rnd12(), 1, 6);
    frame(0, 6, 2, 0, 1'b0);
    drive(1'b1, rnd12(), rnd12(), rnd12(), rnd12(), 3, 2);
    idle(2);
    frame(3, 2, 2, 0, 1'b1);

    cur_req = "R10";
    frame(1, 4, 3, 0, 1'b1);
    idle(6);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired in phase %s", cur_req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule